// File: doc/BRIEF.md
# I2C Master Receive Byte Engine

This block is the receive half of an I2C master at the byte level. Once an external address phase has finished, it is told to begin receiving. It clocks eight data bits in from SDA, most significant bit first, with each bit timed by a half-period tick from an external divider. A completed byte moves into a single holding register for the host. The engine then drives the acknowledge bit for that byte. After the acknowledge phase it closes the byte: it either goes on to the next byte, or generates a STOP or a repeated START that the host has requested.

The host steers the engine through a small set of control writes:
- An acknowledge-select bit chooses ACK or NACK.
- A position bit postpones that choice to the following byte.
- Two self-clearing request bits ask for STOP or repeated START.

Two status flags report the byte flow. One says the holding register has unread data. The other says a further byte has fully arrived in the shift register while the holding register is still unread. While that second flag is set, the engine keeps SCL low after the acknowledge bit. It only continues once the host reads, so no byte is lost.

Top module: `i2c_rx_ack_engine`

## Requirements
- R1: After reset:
  - both status flags are 0;
  - all control readbacks are 0;
  - neither SCL nor SDA is driven low.
- R2: Bits are sampled on each SCL-high tick, MSB first. When the eighth bit arrives and the holding register is empty, the byte is placed in `rd_data_o` and `rxne_o` rises.
- R3: A read strobe with `btf_o` low clears `rxne_o`.
- R4: With the position bit clear, the acknowledge bit of the current byte follows the acknowledge-select bit. A value of 1 drives SDA low (ACK) during both acknowledge half-periods. A value of 0 leaves SDA released (NACK).
- R5: With the position bit set, the byte being received is acknowledged according to the setting held at the previous byte's end. The next byte then takes the current acknowledge-select value. The first byte after a begin strobe is always ACKed in this mode.
- R6: When a byte completes while `rxne_o` is set, the following happens:
  - `btf_o` rises;
  - the byte stays in the shift register;
  - `rd_data_o` keeps the older byte.
  A read then moves the newer byte into `rd_data_o`, clears `btf_o` and leaves `rxne_o` set.
- R7: After the acknowledge phase, while `btf_o` is set, SCL is held low whatever the tick input does, and no bit is sampled.
- R8: A pending STOP request is executed after the acknowledge phase, in three steps:
  1. SCL low with SDA low;
  2. SCL released with SDA low;
  3. both released.
  The request then clears itself.
- R9: A pending repeated-START request is executed after the acknowledge phase, in four steps:
  1. SCL low with SDA released;
  2. both released;
  3. SDA low with SCL released;
  4. both held low until the next begin strobe.
  The request then clears itself.
- R10: When both requests are pending, STOP is generated and both requests are cleared.
- R11: For a one-byte read, the host clears acknowledge-select and position and requests STOP before the byte ends. The byte is then NACKed and followed at once by STOP.
- R12: While the enable input is low, the engine does the following:
  - it sits idle and releases SDA and SCL;
  - it clears flags, control bits and requests;
  - it ignores control writes and begin strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Engine enable; low forces idle |
| tick_i | input | 1 | Half SCL period tick from the divider |
| rx_go_i | input | 1 | Begin receiving (accepted when idle or parked) |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_ack_i | input | 1 | Acknowledge-select value written |
| ctrl_pos_i | input | 1 | Position value written |
| ctrl_stop_i | input | 1 | 1 requests STOP |
| ctrl_start_i | input | 1 | 1 requests repeated START |
| rd_i | input | 1 | Host read strobe of the holding register |
| sda_i | input | 1 | Sampled SDA line |
| rd_data_o | output | DATA_W | Holding register |
| rxne_o | output | 1 | Holding register full |
| btf_o | output | 1 | Shift and holding registers both full |
| ack_o | output | 1 | Acknowledge-select readback |
| pos_o | output | 1 | Position readback |
| stop_o | output | 1 | STOP request pending |
| start_o | output | 1 | Repeated-START request pending |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
The assertions take for granted the following of the inputs:
- `rd_i` is a single-cycle strobe from a host that only reads when a flag says there is data.
- Ticks come no faster than one per clock.
- Control writes are single-cycle strobes.

The directed stimulus keeps to this:
- it drives every tick, read and write as a one-cycle pulse on the falling clock edge;
- it begins reception only from idle or parked;
- it issues reads only while `rxne_o` is set.

With that, the checks on the flags and line drives are exact cycle comparisons.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PARK,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_STRETCH,
    ST_STOP_LO,
    ST_STOP_HI,
    ST_RS_LO,
    ST_RS_HI,
    ST_RS_FALL
  } rx_state_e;
endpackage

// File: rtl/i2c_rx_shift.sv
module i2c_rx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_en_i,
  input  logic              sda_i,
  output logic [DATA_W-1:0] shift_o,
  output logic [DATA_W-1:0] byte_val_o,
  output logic              last_bit_o
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] shift_q;

  assign byte_val_o = {shift_q[DATA_W-2:0], sda_i};
  assign last_bit_o = (cnt_q == LAST);
  assign shift_o    = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (shift_en_i) begin
      shift_q <= byte_val_o;
      cnt_q   <= last_bit_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_rx_hold.sv
module i2c_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              byte_done_i,
  input  logic [DATA_W-1:0] byte_val_i,
  input  logic [DATA_W-1:0] shift_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rxne_o,
  output logic              btf_o
);
  logic [DATA_W-1:0] data_q;
  logic              rxne_q, btf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      rxne_q <= 1'b0;
      btf_q  <= 1'b0;
    end else if (clr_i) begin
      data_q <= '0;
      rxne_q <= 1'b0;
      btf_q  <= 1'b0;
    end else if (byte_done_i) begin
      if (!rxne_q || rd_i) begin
        data_q <= byte_val_i;
        rxne_q <= 1'b1;
      end else begin
        btf_q  <= 1'b1;
      end
    end else if (rd_i) begin
      if (btf_q) begin
        // second slot drains into the holding register
        data_q <= shift_i;
        btf_q  <= 1'b0;
      end else begin
        rxne_q <= 1'b0;
      end
    end
  end

  assign data_o = data_q;
  assign rxne_o = rxne_q;
  assign btf_o  = btf_q;
endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic we_i,
  input  logic wack_i,
  input  logic wpos_i,
  input  logic wstop_i,
  input  logic wstart_i,
  input  logic go_i,
  input  logic byte_done_i,
  input  logic stop_done_i,
  input  logic start_done_i,
  output logic ack_o,
  output logic pos_o,
  output logic stop_o,
  output logic start_o,
  output logic ack_bit_o
);
  logic ack_q, pos_q, defer_q, stop_q, start_q, ack_bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q     <= 1'b0;
      pos_q     <= 1'b0;
      defer_q   <= 1'b1;
      stop_q    <= 1'b0;
      start_q   <= 1'b0;
      ack_bit_q <= 1'b0;
    end else if (clr_i) begin
      ack_q     <= 1'b0;
      pos_q     <= 1'b0;
      defer_q   <= 1'b1;
      stop_q    <= 1'b0;
      start_q   <= 1'b0;
      ack_bit_q <= 1'b0;
    end else begin
      if (we_i) begin
        ack_q <= wack_i;
        pos_q <= wpos_i;
      end
      stop_q  <= (stop_q & ~stop_done_i) | (we_i & wstop_i);
      // a STOP also retires a pending repeated START
      start_q <= (start_q & ~(start_done_i | stop_done_i)) | (we_i & wstart_i);
      if (go_i)             defer_q <= 1'b1;
      else if (byte_done_i) defer_q <= ack_q;
      if (byte_done_i)      ack_bit_q <= pos_q ? defer_q : ack_q;
    end
  end

  assign ack_o     = ack_q;
  assign pos_o     = pos_q;
  assign stop_o    = stop_q;
  assign start_o   = start_q;
  assign ack_bit_o = ack_bit_q;
endmodule

// File: rtl/i2c_rx_seq.sv
module i2c_rx_seq
  import i2c_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic rx_go_i,
  input  logic last_bit_i,
  input  logic btf_i,
  input  logic stop_i,
  input  logic start_i,
  input  logic ack_bit_i,
  output logic go_o,
  output logic shift_en_o,
  output logic byte_done_o,
  output logic stop_done_o,
  output logic start_done_o,
  output logic scl_low_o,
  output logic sda_low_o
);
  rx_state_e st_q, st_d, post_st;

  always_comb begin
    if (btf_i)        post_st = ST_STRETCH;
    else if (stop_i)  post_st = ST_STOP_LO;
    else if (start_i) post_st = ST_RS_LO;
    else              post_st = ST_BIT_LO;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_PARK: if (rx_go_i) st_d = ST_BIT_LO;
      ST_BIT_LO:  if (tick_i) st_d = ST_BIT_HI;
      ST_BIT_HI:  if (tick_i) st_d = last_bit_i ? ST_ACK_LO : ST_BIT_LO;
      ST_ACK_LO:  if (tick_i) st_d = ST_ACK_HI;
      ST_ACK_HI:  if (tick_i) st_d = post_st;
      ST_STRETCH: if (!btf_i) st_d = post_st;
      ST_STOP_LO: if (tick_i) st_d = ST_STOP_HI;
      ST_STOP_HI: if (tick_i) st_d = ST_IDLE;
      ST_RS_LO:   if (tick_i) st_d = ST_RS_HI;
      ST_RS_HI:   if (tick_i) st_d = ST_RS_FALL;
      ST_RS_FALL: if (tick_i) st_d = ST_PARK;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= ST_IDLE;
    else if (!en_i) st_q <= ST_IDLE;
    else            st_q <= st_d;
  end

  assign go_o         = en_i && rx_go_i && (st_q == ST_IDLE || st_q == ST_PARK);
  assign shift_en_o   = en_i && tick_i && (st_q == ST_BIT_HI);
  assign byte_done_o  = shift_en_o && last_bit_i;
  assign stop_done_o  = en_i && tick_i && (st_q == ST_STOP_HI);
  assign start_done_o = en_i && tick_i && (st_q == ST_RS_FALL);

  always_comb begin
    scl_low_o = 1'b0;
    sda_low_o = 1'b0;
    unique case (st_q)
      ST_PARK:    begin scl_low_o = 1'b1; sda_low_o = 1'b1; end
      ST_BIT_LO:  scl_low_o = 1'b1;
      ST_ACK_LO:  begin scl_low_o = 1'b1; sda_low_o = ack_bit_i; end
      ST_ACK_HI:  sda_low_o = ack_bit_i;
      ST_STRETCH: scl_low_o = 1'b1;
      ST_STOP_LO: begin scl_low_o = 1'b1; sda_low_o = 1'b1; end
      ST_STOP_HI: sda_low_o = 1'b1;
      ST_RS_LO:   scl_low_o = 1'b1;
      ST_RS_FALL: sda_low_o = 1'b1;
      default:    ;
    endcase
  end
endmodule

// File: rtl/i2c_rx_ack_engine.sv
module i2c_rx_ack_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rx_go_i,
  input  logic              ctrl_we_i,
  input  logic              ctrl_ack_i,
  input  logic              ctrl_pos_i,
  input  logic              ctrl_stop_i,
  input  logic              ctrl_start_i,
  input  logic              rd_i,
  input  logic              sda_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rxne_o,
  output logic              btf_o,
  output logic              ack_o,
  output logic              pos_o,
  output logic              stop_o,
  output logic              start_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  logic              clr, go, shift_en, byte_done, last_bit;
  logic              stop_done, start_done, ack_bit;
  logic [DATA_W-1:0] shift_q, byte_val;

  assign clr = !en_i;

  i2c_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr | go),
    .shift_en_i (shift_en),
    .sda_i      (sda_i),
    .shift_o    (shift_q),
    .byte_val_o (byte_val),
    .last_bit_o (last_bit)
  );

  i2c_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .byte_done_i (byte_done),
    .byte_val_i  (byte_val),
    .shift_i     (shift_q),
    .rd_i        (rd_i),
    .data_o      (rd_data_o),
    .rxne_o      (rxne_o),
    .btf_o       (btf_o)
  );

  i2c_rx_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .we_i         (ctrl_we_i),
    .wack_i       (ctrl_ack_i),
    .wpos_i       (ctrl_pos_i),
    .wstop_i      (ctrl_stop_i),
    .wstart_i     (ctrl_start_i),
    .go_i         (go),
    .byte_done_i  (byte_done),
    .stop_done_i  (stop_done),
    .start_done_i (start_done),
    .ack_o        (ack_o),
    .pos_o        (pos_o),
    .stop_o       (stop_o),
    .start_o      (start_o),
    .ack_bit_o    (ack_bit)
  );

  i2c_rx_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .tick_i       (tick_i),
    .rx_go_i      (rx_go_i),
    .last_bit_i   (last_bit),
    .btf_i        (btf_o),
    .stop_i       (stop_o),
    .start_i      (start_o),
    .ack_bit_i    (ack_bit),
    .go_o         (go),
    .shift_en_o   (shift_en),
    .byte_done_o  (byte_done),
    .stop_done_o  (stop_done),
    .start_done_o (start_done),
    .scl_low_o    (scl_oe_o),
    .sda_low_o    (sda_oe_o)
  );
endmodule

// File: rtl/i2c_rx_ack_engine_chk.sv
module i2c_rx_ack_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic rd_i,
  input logic rxne_o,
  input logic btf_o,
  input logic stop_o,
  input logic start_o,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic shift_en,
  input logic byte_done
);
  assert_disable_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!rxne_o && !btf_o && !scl_oe_o && !sda_oe_o));

  assert_full_implies_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btf_o |-> rxne_o);

  assert_no_shift_while_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btf_o |-> !shift_en);

  assert_read_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rd_i && rxne_o && !btf_o && !byte_done) |=> !rxne_o);

  assert_stop_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stop_o) |-> (!scl_oe_o && !sda_oe_o));

  assert_restart_park_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(start_o) && !$fell(stop_o) && $past(en_i)) |-> (scl_oe_o && sda_oe_o));
endmodule

bind i2c_rx_ack_engine i2c_rx_ack_engine_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .rd_i      (rd_i),
  .rxne_o    (rxne_o),
  .btf_o     (btf_o),
  .stop_o    (stop_o),
  .start_o   (start_o),
  .scl_oe_o  (scl_oe_o),
  .sda_oe_o  (sda_oe_o),
  .shift_en  (shift_en),
  .byte_done (byte_done)
);

// File: tb/tb_i2c_rx_ack_engine.sv
module tb_i2c_rx_ack_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, tick_i = 1'b0, rx_go_i = 1'b0;
  logic ctrl_we_i = 1'b0, ctrl_ack_i = 1'b0, ctrl_pos_i = 1'b0;
  logic ctrl_stop_i = 1'b0, ctrl_start_i = 1'b0;
  logic rd_i = 1'b0, sda_i = 1'b1;
  logic [DW-1:0] rd_data_o;
  logic rxne_o, btf_o, ack_o, pos_o, stop_o, start_o, scl_oe_o, sda_oe_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  i2c_rx_ack_engine #(.DATA_W(DW)) dut (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i) tick_i = 1'b1;
    @(negedge clk_i) tick_i = 1'b0;
  endtask

  task automatic go();
    @(negedge clk_i) rx_go_i = 1'b1;
    @(negedge clk_i) rx_go_i = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk_i) rd_i = 1'b1;
    @(negedge clk_i) rd_i = 1'b0;
  endtask

  task automatic wr(input logic a, input logic p, input logic s, input logic st);
    @(negedge clk_i);
    ctrl_we_i = 1'b1; ctrl_ack_i = a; ctrl_pos_i = p;
    ctrl_stop_i = s; ctrl_start_i = st;
    @(negedge clk_i);
    ctrl_we_i = 1'b0; ctrl_ack_i = 1'b0; ctrl_pos_i = 1'b0;
    ctrl_stop_i = 1'b0; ctrl_start_i = 1'b0;
  endtask

  task automatic reenable();
    @(negedge clk_i) en_i = 1'b0;
    @(negedge clk_i) en_i = 1'b1;
  endtask

  // leaves the engine in the first acknowledge half-period
  task automatic send(input logic [DW-1:0] b);
    for (int i = DW - 1; i >= 0; i--) begin
      sda_i = b[i];
      step();
      step();
    end
    sda_i = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1", "rxne", rxne_o, 0);
    chk("R1", "btf", btf_o, 0);
    chk("R1", "scl", scl_oe_o, 0);
    chk("R1", "sda", sda_oe_o, 0);
    chk("R1", "ctrl", {ack_o, pos_o, stop_o, start_o}, 0);
  endtask

  task automatic t_ack_basic();
    reenable();
    wr(1, 0, 0, 0);
    go();
    send(8'hA5);
    chk("R2", "data", rd_data_o, 8'hA5);
    chk("R2", "rxne", rxne_o, 1);
    chk("R4", "ack sda", sda_oe_o, 1);
    chk("R4", "ack scl", scl_oe_o, 1);
    step();
    chk("R4", "ack hi scl", scl_oe_o, 0);
    chk("R4", "ack hi sda", sda_oe_o, 1);
    rd();
    chk("R3", "rxne after read", rxne_o, 0);
    step();
    wr(0, 0, 0, 0);
    send(8'h3C);
    chk("R4", "nack sda", sda_oe_o, 0);
    chk("R2", "data2", rd_data_o, 8'h3C);
  endtask

  task automatic t_pos();
    reenable();
    go();
    wr(0, 1, 0, 0);
    send(8'h81);
    chk("R5", "first byte acked", sda_oe_o, 1);
    step();
    step();
    rd();
    send(8'h7E);
    chk("R5", "second byte nacked", sda_oe_o, 0);
    chk("R5", "data", rd_data_o, 8'h7E);
  endtask

  task automatic t_tail();
    reenable();
    wr(1, 0, 0, 0);
    go();
    send(8'h11);
    step();
    step();
    send(8'h22);
    chk("R6", "btf", btf_o, 1);
    chk("R6", "old data kept", rd_data_o, 8'h11);
    step();
    step();
    chk("R7", "stretch scl", scl_oe_o, 1);
    repeat (3) step();
    chk("R7", "still stretched", scl_oe_o, 1);
    chk("R7", "btf held", btf_o, 1);
    wr(1, 0, 1, 0);
    chk("R8", "stop pending", stop_o, 1);
    rd();
    chk("R6", "new data", rd_data_o, 8'h22);
    chk("R6", "btf cleared", btf_o, 0);
    chk("R6", "rxne kept", rxne_o, 1);
    @(negedge clk_i);
    chk("R8", "stop lo", {scl_oe_o, sda_oe_o}, 2'b11);
    step();
    chk("R8", "stop hi", {scl_oe_o, sda_oe_o}, 2'b01);
    step();
    chk("R8", "released", {scl_oe_o, sda_oe_o}, 2'b00);
    chk("R8", "stop self-clear", stop_o, 0);
    rd();
    chk("R3", "rxne final", rxne_o, 0);
  endtask

  task automatic t_single();
    reenable();
    go();
    wr(0, 0, 1, 0);
    send(8'hC3);
    chk("R11", "nack", sda_oe_o, 0);
    step();
    step();
    chk("R11", "stop follows", {scl_oe_o, sda_oe_o}, 2'b11);
    step();
    step();
    chk("R11", "stop done", {stop_o, scl_oe_o, sda_oe_o}, 3'b000);
  endtask

  task automatic t_restart();
    reenable();
    wr(1, 0, 0, 1);
    go();
    send(8'h5A);
    chk("R9", "ack", sda_oe_o, 1);
    step();
    step();
    chk("R9", "rs lo", {scl_oe_o, sda_oe_o}, 2'b10);
    step();
    chk("R9", "rs hi", {scl_oe_o, sda_oe_o}, 2'b00);
    step();
    chk("R9", "rs fall", {scl_oe_o, sda_oe_o}, 2'b01);
    step();
    chk("R9", "park", {scl_oe_o, sda_oe_o}, 2'b11);
    chk("R9", "start self-clear", start_o, 0);
    go();
    chk("R9", "resume from park", {scl_oe_o, sda_oe_o}, 2'b10);
  endtask

  task automatic t_both();
    reenable();
    wr(0, 0, 1, 1);
    go();
    send(8'h0F);
    step();
    step();
    chk("R10", "stop chosen", {scl_oe_o, sda_oe_o}, 2'b11);
    step();
    step();
    chk("R10", "both cleared", {stop_o, start_o}, 2'b00);
    chk("R10", "lines released", {scl_oe_o, sda_oe_o}, 2'b00);
  endtask

  task automatic t_disable();
    reenable();
    wr(1, 0, 0, 0);
    go();
    send(8'h99);
    step();
    step();
    repeat (5) step();
    @(negedge clk_i) en_i = 1'b0;
    @(negedge clk_i);
    chk("R12", "lines", {scl_oe_o, sda_oe_o}, 2'b00);
    chk("R12", "flags", {rxne_o, btf_o}, 2'b00);
    chk("R12", "ack cleared", ack_o, 0);
    wr(1, 1, 1, 1);
    chk("R12", "write ignored", {ack_o, pos_o, stop_o, start_o}, 0);
    go();
    step();
    chk("R12", "go ignored", {scl_oe_o, sda_oe_o}, 2'b00);
    @(negedge clk_i) en_i = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    en_i = 1'b1;
    t_ack_basic();
    t_pos();
    t_tail();
    t_single();
    t_restart();
    t_both();
    t_disable();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule